// File: doc/BRIEF.md
# Twelve-Pin General Purpose I/O Controller with Shared Chip Selects

This block configures twelve general purpose pins and produces the per-pin controls for their tri-state pad cells: output enable, output value and weak pull-up enable. Software uses a two-register read/write port. The first register holds the direction and pull-up enable vectors. The second register holds the output data latch when written and returns the synchronised pad levels when read.

Six pins are shared with serial chip selects. Pins 0 to 4 carry the five active-low chip selects of the second SPI master. Pin 11 carries the first SPI master's chip select, but only while the boot-active input is high. On a shared pin the driven value is the AND of the chip select and the pin's data bit. Software therefore sets such a pin to output with data 1, and the SPI master can then pull it low. On any pin that drives low, the pull-up enable is forced off.

The control path has no sequencing. The block has no state machine and therefore no named states or transitions. All behaviour comes from the configuration registers, the input synchroniser and the combinational pin drive logic.

Top module: `gpio_shared_cs`

## Requirements
- R1: After reset, every pin is an input (pad_oe = 0x000), every pull-up is enabled (pad_pu = 0xFFF), pad_out is 0x000, the data latch is 0 and register 0 reads 0x0FFF0000.
- R2: Register 0 (reg_addr = 0) holds direction in bits [11:0] (1 = output) and pull-up enable in bits [27:16]. All other bits read 0, so writing 0xFFFFFFFF reads back 0x0FFF0FFF.
- R3: Reading register 1 returns the pad levels in bits [11:0], with bits [31:12] at 0. Each level passes through two flops, so a pad change shows after the second rising edge and not after the first. The read never returns the written data.
- R4: Writing register 1 loads the data latch from wdata[11:0]. On an output pin with no chip-select gating (pins 5 to 10), pad_out equals the data bit from the cycle after the write.
- R5: A data write to an input pin is kept in the latch and takes effect when the pin is later switched to output.
- R6: For pins 0 to 4, pad_out[i] = data[i] AND spi2_cs_n[i] while the pin is an output. A chip select that is high leaves the data bit unchanged.
- R7: While boot_active is 1, pad_out[11] = data[11] AND spi1_cs_n. While boot_active is 0, pin 11 ignores spi1_cs_n.
- R8: pad_pu equals the pull-up bit, except that it is forced to 0 on any pin that is an output driving 0, whether the 0 comes from the data bit or from a chip select.
- R9: pad_oe follows the direction bits, and pad_out is 0 on every input pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = direction/pull, 1 = data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| pad_in | input | 12 | Pad levels from the pad cells |
| spi2_cs_n | input | 5 | Second SPI master chip selects, active low |
| spi1_cs_n | input | 1 | First SPI master chip select, active low |
| boot_active | input | 1 | High while booting from external EEPROM |
| pad_oe | output | 12 | Per-pin output enable |
| pad_out | output | 12 | Per-pin output value |
| pad_pu | output | 12 | Per-pin pull-up enable |

## Verification
A register write is taken on one rising edge. The new direction, data and pull-up values appear on pad_oe, pad_out, pad_pu and reg_rdata after that edge. The bench therefore samples one time step after the following falling edge. Chip-select and boot-active changes reach the pad outputs with no clock at all, so the bench changes them on a falling edge and checks one time step later. Pad input changes reach register 1 only after two rising edges. The bench checks the old value after the first edge and the new value after the second.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PIN_COUNT   = 12;
    localparam int CS2_COUNT   = 5;
    localparam int BOOT_PIN    = 11;
    localparam int REG_W       = 32;
    localparam int PULL_LSB    = 16;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        SEL_CFG  = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int N        = PIN_COUNT,
    parameter int W        = REG_W,
    parameter int PULL_POS = PULL_LSB
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [N-1:0] dir_q,
    output logic [N-1:0] pull_q,
    output logic [N-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            pull_q <= '1;
            data_q <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_CFG: begin
                    dir_q  <= wdata[N-1:0];
                    pull_q <= wdata[PULL_POS +: N];
                end
                SEL_DATA: data_q <= wdata[N-1:0];
            endcase
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_pkg::*;
#(
    parameter int N      = PIN_COUNT,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_pkg::*;
#(
    parameter int N        = PIN_COUNT,
    parameter int CS2_N    = CS2_COUNT,
    parameter int BOOT_IDX = BOOT_PIN
) (
    input  logic [N-1:0]     dir,
    input  logic [N-1:0]     pull,
    input  logic [N-1:0]     data,
    input  logic [CS2_N-1:0] spi2_cs_n,
    input  logic             spi1_cs_n,
    input  logic             boot_active,
    output logic [N-1:0]     oe,
    output logic [N-1:0]     out,
    output logic [N-1:0]     pu
);
    logic [N-1:0] gate;
    logic [N-1:0] level;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pin
            if (i < CS2_N) begin : g_cs2
                assign gate[i] = spi2_cs_n[i];
            end else if (i == BOOT_IDX) begin : g_boot
                assign gate[i] = boot_active ? spi1_cs_n : 1'b1;
            end else begin : g_plain
                assign gate[i] = 1'b1;
            end
            assign level[i] = data[i] & gate[i];
            assign oe[i]    = dir[i];
            assign out[i]   = dir[i] & level[i];
            assign pu[i]    = pull[i] & ~(dir[i] & ~level[i]);
        end
    endgenerate
endmodule

// File: rtl/gpio_shared_cs.sv
module gpio_shared_cs
    import gpio_pkg::*;
#(
    parameter int N        = PIN_COUNT,
    parameter int CS2_N    = CS2_COUNT,
    parameter int BOOT_IDX = BOOT_PIN,
    parameter int W        = REG_W,
    parameter int PULL_POS = PULL_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [W-1:0]     reg_wdata,
    output logic [W-1:0]     reg_rdata,
    input  logic [N-1:0]     pad_in,
    input  logic [CS2_N-1:0] spi2_cs_n,
    input  logic             spi1_cs_n,
    input  logic             boot_active,
    output logic [N-1:0]     pad_oe,
    output logic [N-1:0]     pad_out,
    output logic [N-1:0]     pad_pu
);
    logic [N-1:0] dir_q, pull_q, data_q, pad_sync;
    reg_sel_e     sel;

    assign sel = reg_sel_e'(reg_addr);

    gpio_cfg_regs #(.N(N), .W(W), .PULL_POS(PULL_POS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(sel), .wdata(reg_wdata),
        .dir_q(dir_q), .pull_q(pull_q), .data_q(data_q)
    );

    gpio_in_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
    );

    gpio_pin_drive #(.N(N), .CS2_N(CS2_N), .BOOT_IDX(BOOT_IDX)) u_drive (
        .dir(dir_q), .pull(pull_q), .data(data_q),
        .spi2_cs_n(spi2_cs_n), .spi1_cs_n(spi1_cs_n), .boot_active(boot_active),
        .oe(pad_oe), .out(pad_out), .pu(pad_pu)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CFG: begin
                reg_rdata[N-1:0]          = dir_q;
                reg_rdata[PULL_POS +: N]  = pull_q;
            end
            SEL_DATA: reg_rdata[N-1:0] = pad_sync;
        endcase
    end
endmodule

// File: rtl/gpio_shared_cs_checker.sv
module gpio_shared_cs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_addr,
    input logic [31:0] reg_rdata,
    input logic [11:0] pad_in,
    input logic [4:0]  spi2_cs_n,
    input logic        spi1_cs_n,
    input logic        boot_active,
    input logic [11:0] pad_oe,
    input logic [11:0] pad_out,
    input logic [11:0] pad_pu
);
    logic [1:0] run_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_cnt <= '0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    assert_pu_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~pad_out & pad_pu) == 12'h000);

    assert_input_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == 12'h000);

    assert_cs2_pulls_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out[4:0] & ~spi2_cs_n) == 5'b00000);

    assert_boot_cs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_active && !spi1_cs_n) |-> !pad_out[11]);

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b0) |-> ((reg_rdata & 32'hF000_F000) == 32'h0));

    assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b1 && run_cnt == 2'd3) |->
            (reg_rdata == {20'h0, $past(pad_in, 2)}));
endmodule

bind gpio_shared_cs gpio_shared_cs_checker u_checker (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .spi2_cs_n(spi2_cs_n), .spi1_cs_n(spi1_cs_n),
    .boot_active(boot_active), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
);

// File: tb/tb_gpio_shared_cs.sv
module tb_gpio_shared_cs;
    localparam time HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] pad_in = '0;
    logic [4:0]  spi2_cs_n = 5'h1F;
    logic        spi1_cs_n = 1'b1;
    logic        boot_active = 1'b0;
    logic [11:0] pad_oe, pad_out, pad_pu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0] m_dir = 12'h000, m_pull = 12'hFFF, m_data = 12'h000;

    always #HALF clk = ~clk;

    gpio_shared_cs dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .spi2_cs_n(spi2_cs_n), .spi1_cs_n(spi1_cs_n), .boot_active(boot_active),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    function automatic logic [11:0] exp_out(logic [11:0] d, logic [11:0] v,
                                            logic [4:0] c2, logic c1, logic b);
        logic [11:0] g = 12'hFFF;
        g[4:0] = c2;
        if (b) g[11] = c1;
        return d & v & g;
    endfunction

    function automatic logic [11:0] exp_pu(logic [11:0] d, logic [11:0] p,
                                           logic [11:0] o);
        return p & ~(d & ~o);
    endfunction

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic check_pins(string tag);
        logic [11:0] eo;
        eo = exp_out(m_dir, m_data, spi2_cs_n, spi1_cs_n, boot_active);
        check_eq({tag, " R9 oe"}, {20'h0, pad_oe}, {20'h0, m_dir});
        check_eq({tag, " out"}, {20'h0, pad_out}, {20'h0, eo});
        check_eq({tag, " R8 pu"}, {20'h0, pad_pu}, {20'h0, exp_pu(m_dir, m_pull, eo)});
    endtask

    task automatic reg_write(logic a, logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 1'b0) begin
            m_dir = v[11:0]; m_pull = v[27:16];
        end else begin
            m_data = v[11:0];
        end
        #1;
    endtask

    task automatic set_cs(logic [4:0] c2, logic c1, logic b);
        @(negedge clk);
        spi2_cs_n = c2; spi1_cs_n = c1; boot_active = b;
        #1;
    endtask

    initial begin
        #(2 * HALF * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] old_pad;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        reg_addr = 1'b0;
        #1;
        check_eq("R1 cfg read", reg_rdata, 32'h0FFF_0000);
        check_pins("R1");

        // R2 layout and unused bits
        reg_write(1'b0, 32'hFFFF_FFFF);
        reg_addr = 1'b0; #1;
        check_eq("R2 readback", reg_rdata, 32'h0FFF_0FFF);
        reg_write(1'b0, 32'h0ABC_0123);
        reg_addr = 1'b0; #1;
        check_eq("R2 fields", reg_rdata, 32'h0ABC_0123);

        // R5 data stored while input
        reg_write(1'b0, 32'h0000_0000);
        reg_write(1'b1, 32'h0000_05E0);
        check_pins("R5 input R9");
        check_eq("R9 no drive", {20'h0, pad_out}, 32'h0);
        reg_write(1'b0, 32'h0FFF_0FFF);
        check_eq("R5 switch to out", {20'h0, pad_out}, 32'h0000_05E0);
        check_eq("R4 plain pins", {26'h0, pad_out[10:5]}, {26'h0, 6'h2F});
        check_pins("R4");

        // R8 driving low turns pull off
        check_eq("R8 pu forced", {20'h0, pad_pu}, 32'h0000_05E0);

        // R6 second SPI chip selects
        reg_write(1'b1, 32'h0000_0FFF);
        set_cs(5'b10110, 1'b1, 1'b0);
        check_eq("R6 cs gating", {27'h0, pad_out[4:0]}, 32'h16);
        check_eq("R8 cs low pu", {27'h0, pad_pu[4:0]}, 32'h16);
        check_pins("R6");

        // R7 boot chip select
        set_cs(5'h1F, 1'b0, 1'b0);
        check_eq("R7 boot off ignores", {31'h0, pad_out[11]}, 32'h1);
        set_cs(5'h1F, 1'b0, 1'b1);
        check_eq("R7 boot on gates", {31'h0, pad_out[11]}, 32'h0);
        check_eq("R7 pu off", {31'h0, pad_pu[11]}, 32'h0);
        set_cs(5'h1F, 1'b1, 1'b1);
        check_eq("R7 cs idle", {31'h0, pad_out[11]}, 32'h1);

        // R3 synchroniser latency and readback source
        reg_addr = 1'b1;
        @(negedge clk);
        pad_in = 12'h5A3;
        @(posedge clk); @(negedge clk);
        old_pad = 12'h000;
        check_eq("R3 not after one edge", reg_rdata, {20'h0, old_pad});
        @(posedge clk); @(negedge clk); #1;
        check_eq("R3 after two edges", reg_rdata, 32'h0000_05A3);
        check_eq("R3 not data latch", {31'h0, (reg_rdata[11:0] == m_data)}, 32'h0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom % 4;
            case (op)
                0: reg_write(1'b0, $urandom);
                1: reg_write(1'b1, $urandom);
                2: set_cs((($urandom % 2) != 0) ? 5'h1F : 5'($urandom),
                          ($urandom % 3) != 0, ($urandom % 2) != 0);
                default: begin
                    logic [11:0] np;
                    np = 12'($urandom);
                    reg_addr = 1'b1;
                    @(negedge clk);
                    pad_in = np;
                    @(posedge clk); @(posedge clk); @(negedge clk); #1;
                    check_eq("R3 random pad", reg_rdata, {20'h0, np});
                end
            endcase
            check_pins("R4 R6 R7 random");
            reg_addr = 1'b0; #1;
            check_eq("R2 random cfg", reg_rdata, {4'h0, m_pull, 4'h0, m_dir});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule